// File: doc/BRIEF.md
# Shifted Second-Operand Generator

This combinational unit forms the second source operand of a 32-bit data-processing instruction, together with the carry bit that comes out of the shifter. It takes the instruction word, the values of the two register operands that can feed the shifter (the value being shifted and the register holding a shift amount), and the current carry flag. It returns the operand value and the shifter carry. A separate stage reads the registers, and a separate ALU consumes both outputs and decides whether to update the flags.

There are two operand forms. The immediate form takes an 8-bit constant and rotates it right by an even amount. The register form shifts a register left or right, logically or arithmetically, or rotates it. The amount comes either from a 5-bit instruction field or from the low byte of a second register. Several encodings are special. A zero immediate amount means a shift of 32 for the right shifts and a one-bit rotate through carry for rotate. Register amounts of 32 and above also have their own result and carry rules.

Top module: `opsh_operand`

## Requirements
- R1: Instruction bit 25 selects the form: 1 selects the rotated 8-bit constant, 0 selects the shifted register. Bits outside [25] and [11:0] of the instruction, and bits above [7:0] of rs_i, have no effect on either output.
- R2: In the immediate form with ir_i[11:8] nonzero, operand_o is ir_i[7:0] zero-extended and rotated right by 2*ir_i[11:8]. carry_o is bit 31 of that result.
- R3: In the immediate form with ir_i[11:8] zero, operand_o is ir_i[7:0] zero-extended and carry_o equals carry_i.
- R4: In the register form, ir_i[6:5] selects the kind (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right). ir_i[4]=0 takes the amount from ir_i[11:7], and ir_i[4]=1 takes it from rs_i[7:0].
- R5: For an amount n with 0<n<32, the result is rm_i shifted or rotated by n. carry_o is the last bit shifted out: rm_i[32-n] for left shifts and rm_i[n-1] for the other kinds.
- R6: An immediate left shift of 0 returns rm_i unchanged with carry_o equal to carry_i.
- R7: An immediate right logical shift of 0 acts as a shift of 32: the result is 0 and carry_o is rm_i[31]. An immediate right arithmetic shift of 0 makes every result bit and carry_o equal to rm_i[31].
- R8: An immediate rotate of 0 is a one-bit rotate through carry: the result is {carry_i, rm_i[31:1]} and carry_o is rm_i[0].
- R9: A register-specified amount with rs_i[7:0]==0 returns rm_i unchanged with carry_o equal to carry_i, for every kind.
- R10: A register left or right logical shift by exactly 32 gives a result of 0, with carry_o equal to rm_i[0] (left) or rm_i[31] (right). Amounts from 33 to 255 give a result of 0 and carry_o of 0.
- R11: A register right arithmetic shift by 32 to 255 fills the result with rm_i[31], and carry_o is rm_i[31].
- R12: A register rotate uses rs_i[4:0]. When rs_i[7:0] is nonzero and rs_i[4:0] is zero, the result is rm_i and carry_o is rm_i[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_i | input | 32 | Instruction word |
| rm_i | input | DATA_W | Value to be shifted in the register form |
| rs_i | input | DATA_W | Register holding the shift amount (low byte used) |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | DATA_W | Second operand for the ALU |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the unit with its default 32-bit datapath, since the 32-bit boundary is where the special encodings apply. At that width the bench can try every immediate amount and rotate field directly, and it can try every register amount around and past 32, including 255 and values whose upper rs_i bits are set. It compares each result with a bit-serial model that shifts one position at a time. That model makes the last-bit-out carry and the saturation beyond 32 emerge step by step, rather than being written as closed-form cases.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  localparam int unsigned FORM_BIT   = 25;
  localparam int unsigned IMM8_W     = 8;
  localparam int unsigned ROT_FLD_W  = 4;
  localparam int unsigned SH_FLD_LSB = 4;
  localparam int unsigned SH_FLD_W   = 8;
  localparam int unsigned RS_AMT_W   = 8;
endpackage

// File: rtl/opsh_amt_decode.sv
module opsh_amt_decode
  import opsh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = RS_AMT_W
) (
  input  logic [SH_FLD_W-1:0] fld_i,   // ir[11:4]
  input  logic [AMT_W-1:0]    rs_amt_i,
  output sh_kind_e            kind_o,
  output logic [AMT_W-1:0]    amt_o,
  output logic                rrx_o
);
  localparam int unsigned IMM_AMT_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic                 by_reg;
  logic [IMM_AMT_W-1:0] imm_amt;

  assign by_reg  = fld_i[0];
  assign kind_o  = sh_kind_e'(fld_i[2:1]);
  assign imm_amt = fld_i[3 +: IMM_AMT_W];

  always_comb begin
    rrx_o = 1'b0;
    amt_o = AMT_W'(imm_amt);
    if (by_reg) begin
      amt_o = rs_amt_i;
    end else if (imm_amt == '0) begin
      unique case (kind_o)
        SH_LSR, SH_ASR: amt_o = FULL_AMT;  // zero encodes a full-width shift
        SH_ROR:         rrx_o = 1'b1;
        default:        amt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/opsh_reg_shift.sv
module opsh_reg_shift
  import opsh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = RS_AMT_W
) (
  input  logic [DATA_W-1:0] rm_i,
  input  sh_kind_e          kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              rrx_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int unsigned SAT_W = $clog2(DATA_W + 2);
  localparam int unsigned ROT_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] SAT_MAX  = AMT_W'(DATA_W + 1);
  localparam logic [SAT_W-1:0] ASR_MAX  = SAT_W'(DATA_W);

  logic [SAT_W-1:0]    sat_amt;
  logic [SAT_W-1:0]    asr_amt;
  logic [ROT_W-1:0]    rot_amt;
  logic [DATA_W:0]     lsl_ext;   // {carry, result}
  logic [DATA_W:0]     lsr_ext;   // {result, carry}
  logic [DATA_W:0]     asr_ext;   // {result, carry}
  logic [2*DATA_W-1:0] ror_dbl;
  logic [DATA_W-1:0]   ror_res;

  // amounts past width+1 behave like width+1: everything shifted out
  assign sat_amt = (amt_i > SAT_MAX) ? SAT_W'(SAT_MAX) : SAT_W'(amt_i);
  assign asr_amt = (sat_amt > ASR_MAX) ? ASR_MAX : sat_amt;
  assign rot_amt = amt_i[ROT_W-1:0];

  assign lsl_ext = {1'b0, rm_i} << sat_amt;
  assign lsr_ext = {rm_i, 1'b0} >> sat_amt;
  assign asr_ext = (DATA_W + 1)'($signed({rm_i, 1'b0}) >>> asr_amt);
  assign ror_dbl = {rm_i, rm_i} >> rot_amt;
  assign ror_res = ror_dbl[DATA_W-1:0];

  always_comb begin
    res_o   = rm_i;
    carry_o = carry_i;
    if (rrx_i) begin
      res_o   = {carry_i, rm_i[DATA_W-1:1]};
      carry_o = rm_i[0];
    end else if (amt_i != '0) begin
      unique case (kind_i)
        SH_LSL: begin
          res_o   = lsl_ext[DATA_W-1:0];
          carry_o = lsl_ext[DATA_W];
        end
        SH_LSR: begin
          res_o   = lsr_ext[DATA_W:1];
          carry_o = lsr_ext[0];
        end
        SH_ASR: begin
          res_o   = asr_ext[DATA_W:1];
          carry_o = asr_ext[0];
        end
        default: begin
          res_o   = ror_res;
          carry_o = ror_res[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/opsh_imm_rot.sv
module opsh_imm_rot
  import opsh_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [IMM8_W-1:0]    imm_i,
  input  logic [ROT_FLD_W-1:0] rot_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    val_o,
  output logic                 carry_o
);
  localparam int unsigned ROT_W = ROT_FLD_W + 1;

  logic [DATA_W-1:0]   ext;
  logic [ROT_W-1:0]    rot_amt;
  logic [2*DATA_W-1:0] dbl;

  assign ext     = DATA_W'(imm_i);
  assign rot_amt = {rot_i, 1'b0};
  assign dbl     = {ext, ext} >> rot_amt;
  assign val_o   = dbl[DATA_W-1:0];
  assign carry_o = (rot_i == '0) ? carry_i : dbl[DATA_W-1];
endmodule

// File: rtl/opsh_operand.sv
module opsh_operand
  import opsh_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [31:0]       ir_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o
);
  localparam int unsigned AMT_W = RS_AMT_W;

  sh_kind_e          kind;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic [DATA_W-1:0] imm_res;
  logic              imm_c;
  logic              imm_form;
  logic              unused_bits;

  assign imm_form    = ir_i[FORM_BIT];
  assign unused_bits = ^{ir_i[31:26], ir_i[24:12], rs_i[DATA_W-1:AMT_W]};

  opsh_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .fld_i    (ir_i[SH_FLD_LSB +: SH_FLD_W]),
    .rs_amt_i (rs_i[AMT_W-1:0]),
    .kind_o   (kind),
    .amt_o    (amt),
    .rrx_o    (rrx)
  );

  opsh_reg_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .rm_i    (rm_i),
    .kind_i  (kind),
    .amt_i   (amt),
    .rrx_i   (rrx),
    .carry_i (carry_i),
    .res_o   (sh_res),
    .carry_o (sh_c)
  );

  opsh_imm_rot #(.DATA_W(DATA_W)) u_rot (
    .imm_i   (ir_i[IMM8_W-1:0]),
    .rot_i   (ir_i[IMM8_W +: ROT_FLD_W]),
    .carry_i (carry_i),
    .val_o   (imm_res),
    .carry_o (imm_c)
  );

  assign operand_o = imm_form ? imm_res : sh_res;
  assign carry_o   = imm_form ? imm_c   : sh_c;

  // port-level checks of the special encodings
  always_comb begin
    if (imm_form && ir_i[11:8] == 4'd0) begin
      a_r3_zero_rot_passes_carry: assert (carry_o == carry_i && operand_o == DATA_W'(ir_i[7:0]))
        else $error("R3 zero rotate mismatch");
    end
    if (!imm_form && ir_i[4] && rs_i[7:0] == 8'd0) begin
      a_r9_zero_reg_amount: assert (operand_o == rm_i && carry_o == carry_i)
        else $error("R9 zero register amount mismatch");
    end
    if (!imm_form && ir_i[4] && ir_i[6:5] == 2'b01 && rs_i[7:0] > 8'd32) begin
      a_r10_lsr_past_width: assert (operand_o == '0 && carry_o == 1'b0)
        else $error("R10 right shift past width mismatch");
    end
    if (!imm_form && ir_i[4] && ir_i[6:5] == 2'b10 && rs_i[7:0] >= 8'd32) begin
      a_r11_asr_fill: assert (operand_o == {DATA_W{rm_i[DATA_W-1]}} && carry_o == rm_i[DATA_W-1])
        else $error("R11 arithmetic fill mismatch");
    end
    if (!imm_form && !ir_i[4] && ir_i[6:5] == 2'b11 && ir_i[11:7] == 5'd0) begin
      a_r8_rrx: assert (operand_o[DATA_W-1] == carry_i && carry_o == rm_i[0])
        else $error("R8 rotate through carry mismatch");
    end
  end
endmodule

// File: tb/opsh_operand_tb.sv
module opsh_operand_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned NVEC = 10;
  localparam int unsigned VEC_W = 4*32 + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] ir;
  logic [DW-1:0] rm, rs;
  logic cin;
  logic [DW-1:0] op;
  logic cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  opsh_operand #(.DATA_W(DW)) u_dut (
    .ir_i(ir), .rm_i(rm), .rs_i(rs), .carry_i(cin),
    .operand_o(op), .carry_o(cout)
  );

  // {ir, rm, rs, cin, exp_op, exp_c}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {32'h020000FF, 32'h0, 32'h0, 1'b1, 32'h000000FF, 1'b1},
    {32'h020001FF, 32'h0, 32'h0, 1'b0, 32'hC000003F, 1'b1},
    {32'h00000020, 32'h80000001, 32'h0, 1'b0, 32'h00000000, 1'b1},
    {32'h00000040, 32'h80000000, 32'h0, 1'b0, 32'hFFFFFFFF, 1'b1},
    {32'h00000060, 32'h00000003, 32'h0, 1'b1, 32'h80000001, 1'b1},
    {32'h00000010, 32'h00000001, 32'h20, 1'b0, 32'h00000000, 1'b1},
    {32'h00000030, 32'hFFFFFFFF, 32'h21, 1'b1, 32'h00000000, 1'b0},
    {32'h00000070, 32'h80000002, 32'h40, 1'b0, 32'h80000002, 1'b1},
    {32'hFDFFF010, 32'h12345678, 32'hFFFFFF00, 1'b1, 32'h12345678, 1'b1},
    {32'h00000180, 32'hE0000001, 32'h0, 1'b0, 32'h00000008, 1'b1}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2: return "R7";
      3: return "R7";
      4: return "R8";
      5: return "R10";
      6: return "R10";
      7: return "R12";
      8: return "R1";   // upper ir/rs bits set, form bit clear, zero register amount
      default: return "R5";
    endcase
  endfunction

  // bit-serial model: one position per step
  function automatic logic [DW:0] ref_model(logic [31:0] i_ir, logic [DW-1:0] i_rm,
                                            logic [DW-1:0] i_rs, logic i_c);
    logic [DW-1:0] r;
    logic c;
    int n;
    if (i_ir[25]) begin
      r = DW'(i_ir[7:0]);
      n = 2 * int'(i_ir[11:8]);
      for (int k = 0; k < n; k++) r = {r[0], r[DW-1:1]};
      c = (n == 0) ? i_c : r[DW-1];
      return {c, r};
    end
    r = i_rm;
    c = i_c;
    n = i_ir[4] ? int'(i_rs[7:0]) : int'(i_ir[11:7]);
    if (!i_ir[4] && n == 0) begin
      case (i_ir[6:5])
        2'b00: ;
        2'b01: begin r = '0; c = i_rm[DW-1]; end
        2'b10: begin r = {DW{i_rm[DW-1]}}; c = i_rm[DW-1]; end
        default: begin r = {i_c, i_rm[DW-1:1]}; c = i_rm[0]; end
      endcase
      return {c, r};
    end
    for (int k = 0; k < n; k++) begin
      case (i_ir[6:5])
        2'b00: begin c = r[DW-1]; r = {r[DW-2:0], 1'b0}; end
        2'b01: begin c = r[0]; r = {1'b0, r[DW-1:1]}; end
        2'b10: begin c = r[0]; r = {r[DW-1], r[DW-1:1]}; end
        default: begin c = r[0]; r = {r[0], r[DW-1:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  task automatic run(input logic [31:0] t_ir, input logic [DW-1:0] t_rm,
                     input logic [DW-1:0] t_rs, input logic t_c,
                     input logic [DW-1:0] e_op, input logic e_c, input string req);
    @(posedge clk);
    #1;
    ir = t_ir; rm = t_rm; rs = t_rs; cin = t_c;
    @(negedge clk);
    checks++;
    if (op !== e_op || cout !== e_c) begin
      errors++;
      $display("FAIL %s ir=%h rm=%h rs=%h cin=%b: got op=%h c=%b, expected op=%h c=%b",
               req, t_ir, t_rm, t_rs, t_c, op, cout, e_op, e_c);
    end
  endtask

  task automatic run_ref(input logic [31:0] t_ir, input logic [DW-1:0] t_rm,
                         input logic [DW-1:0] t_rs, input logic t_c, input string req);
    logic [DW:0] e;
    e = ref_model(t_ir, t_rm, t_rs, t_c);
    run(t_ir, t_rm, t_rs, t_c, e[DW-1:0], e[DW], req);
  endtask

  function automatic string reg_req(int kind, int n);
    if (n == 0) return "R9";
    if (n < 32) return "R5";
    if (kind < 2) return "R10";
    if (kind == 2) return "R11";
    return "R12";
  endfunction

  function automatic string imm_req(int kind, int n);
    if (n != 0) return "R5";
    case (kind)
      0: return "R6";
      1, 2: return "R7";
      default: return "R8";
    endcase
  endfunction

  localparam logic [DW-1:0] PAT [4] = '{32'h80000001, 32'h7FFFFFFE, 32'hA5C30F96, 32'h4000_0002};
  localparam int REG_AMT [6] = '{63, 64, 96, 128, 224, 255};

  initial begin
    ir = '0; rm = '0; rs = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset/idle: all-zero inputs decode as imm left shift of 0 (R6)
    run(32'h0, '0, '0, 1'b0, '0, 1'b0, "R6");

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][129:98], VEC[i][97:66], VEC[i][65:34], VEC[i][33],
          VEC[i][32:1], VEC[i][0], vec_req(i));
    end

    // R4, R5..R8: every immediate shift amount and kind
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++)
            run_ref((32'(a) << 7) | (32'(k) << 5), PAT[p], 32'hFFFFFFFF, c[0], imm_req(k, a));

    // R4, R5, R9..R12: register amounts, upper rs bits varied (R1)
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 47; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            int n;
            n = (a < 41) ? a : REG_AMT[a - 41];
            run_ref(32'h00000010 | (32'(k) << 5) | (32'(p) << 7), PAT[p],
                    {(p[0] ? 24'hABCDEF : 24'h0), 8'(n)}, c[0], reg_req(k, n));
          end

    // R1, R2, R3: immediate rotations; register-form bits set to show they are ignored
    for (int r = 0; r < 16; r++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          run_ref(32'h02000000 | (32'(r) << 8) | (b[0] ? 32'h81 : 32'h7E), PAT[b], PAT[b + 2],
                  c[0], (r == 0) ? "R3" : "R2");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule